// File: doc/BRIEF.md
# Quartic spline polynomial evaluator

This block evaluates the bivariate quartic spline polynomial P = z·u⁴ + 4a·v·u³ + 6b·u²·v² + 4w·u·v³ + q·v⁴ for signed fixed-width operands. It uses a factored form that shares powers of u and v: d1 = v², then P = u³·(u·z + 4a·v) + d1·(q·d1 + u·(4w·v + 6b·u)). This form needs eleven multiplications rather than the seventeen of a nested Horner evaluation.

The hardware has one multiplier and one adder, both time-shared. A sixteen-step fixed microcode sequence drives them, issuing one operation per cycle. Partial results are held in a small register file that also latches the operands.

The constants 4 and 6 need no multiplier steps. They are applied as shifted inputs to the adder: 4x is a two-place shift, and 6x is the sum of a two-place shift and a one-place shift.

A caller raises `start` with the operands while the block is idle. It then waits for the one-cycle `done` pulse and takes `result`, which keeps its value until the next completion.

Top module: `quartic_spline_eval`

## Requirements
- R1: When `done` is high, `result` equals the exact two's-complement value of z·u⁴ + 4a·v·u³ + 6b·u²·v² + 4w·u·v³ + q·v⁴, computed from the operands sampled when the run was accepted. This includes all-minimum and all-maximum operands. `result` is 5·W+4 bits wide, so no value overflows.
- R2: A `start` that is high while `busy` is low is accepted at that clock edge. The operands are sampled at that edge, and `busy` is high from the next cycle.
- R3: A run takes sixteen steps, each one multiplier or adder operation, for a total of eleven multiplications. `done` is high for exactly one cycle: the sixteenth cycle after the cycle in which `start` was accepted. In that same cycle `busy` is low again.
- R4: While `busy` is high, `start` and any change to the operands are ignored. The run in progress neither restarts nor changes its result.
- R5: `result` changes only in a cycle where `done` is high, and otherwise holds its last value.
- R6: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new evaluation |
| u | input | W | Signed first variable |
| v | input | W | Signed second variable |
| z | input | W | Signed coefficient of u⁴ |
| a | input | W | Signed coefficient of the v·u³ term |
| b | input | W | Signed coefficient of the u²·v² term |
| w | input | W | Signed coefficient of the u·v³ term |
| q | input | W | Signed coefficient of v⁴ |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | 5·W+4 | Signed polynomial value |

## Verification
The assertions assume that reset is held low long enough to clear all state. They also assume `start` is a plain level sampled at clock edges, with no rule tying it to `busy`. The properties must therefore hold for any pattern of start requests, including requests that arrive during a run. The stimulus drives a new random `start` and new random operands every cycle, so operands often change and start is often requested in the middle of a run. It also mixes in runs where every operand is at the most negative or most positive value, so the widest intermediate products are reached.

// File: rtl/quartic_pkg.sv
package quartic_pkg;

    typedef enum logic {OP_MUL, OP_ADD} op_kind_e;

    // Register file slots: operands first, then partial results.
    typedef enum logic [3:0] {
        S_U, S_V, S_Z, S_A, S_B, S_W, S_Q,
        S_U2, S_U3, S_D1, S_T1, S_T2, S_T3, S_T4
    } slot_e;

    localparam int NOPND  = 7;
    localparam int NSLOT  = 14;
    localparam int NSTEP  = 16;
    localparam int NMUL   = 11;
    localparam int STEP_W = $clog2(NSTEP);

    typedef struct packed {
        op_kind_e   kind;
        slot_e      src_x;
        logic [1:0] sh_x;
        slot_e      src_y;
        logic [1:0] sh_y;
        slot_e      dst;
        logic       last;
    } uop_t;

    function automatic uop_t mul_op(slot_e x, slot_e y, slot_e d);
        return '{kind: OP_MUL, src_x: x, sh_x: 2'd0, src_y: y, sh_y: 2'd0,
                 dst: d, last: 1'b0};
    endfunction

    function automatic uop_t add_op(slot_e x, logic [1:0] sx, slot_e y,
                                    logic [1:0] sy, slot_e d, logic fin);
        return '{kind: OP_ADD, src_x: x, sh_x: sx, src_y: y, sh_y: sy,
                 dst: d, last: fin};
    endfunction

    // Fixed schedule: 11 multiplies, 5 adds, shifts implement 4x and 6x.
    function automatic uop_t step_uop(logic [STEP_W-1:0] s);
        case (s)
            4'd0:    return mul_op(S_U,  S_U,  S_U2);
            4'd1:    return mul_op(S_U2, S_U,  S_U3);
            4'd2:    return mul_op(S_V,  S_V,  S_D1);
            4'd3:    return mul_op(S_U,  S_Z,  S_T1);
            4'd4:    return mul_op(S_A,  S_V,  S_T2);
            4'd5:    return add_op(S_T1, 2'd0, S_T2, 2'd2, S_T1, 1'b0);
            4'd6:    return mul_op(S_U3, S_T1, S_T1);
            4'd7:    return mul_op(S_Q,  S_D1, S_T2);
            4'd8:    return mul_op(S_W,  S_V,  S_T3);
            4'd9:    return mul_op(S_B,  S_U,  S_T4);
            4'd10:   return add_op(S_T4, 2'd2, S_T4, 2'd1, S_T4, 1'b0);
            4'd11:   return add_op(S_T3, 2'd2, S_T4, 2'd0, S_T3, 1'b0);
            4'd12:   return mul_op(S_U,  S_T3, S_T3);
            4'd13:   return add_op(S_T2, 2'd0, S_T3, 2'd0, S_T2, 1'b0);
            4'd14:   return mul_op(S_D1, S_T2, S_T2);
            default: return add_op(S_T1, 2'd0, S_T2, 2'd0, S_T1, 1'b1);
        endcase
    endfunction

endpackage

// File: rtl/quartic_seq.sv
module quartic_seq
    import quartic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic load,
    output uop_t uop
);

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.step = '0;
            end
        end else if (seq_q.step == STEP_W'(NSTEP - 1)) begin
            seq_d.busy = 1'b0;
            seq_d.step = '0;
        end else begin
            seq_d.step = seq_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;
    assign load = start && !seq_q.busy;
    assign uop  = step_uop(seq_q.step);

endmodule

// File: rtl/quartic_regfile.sv
module quartic_regfile
    import quartic_pkg::*;
#(
    parameter int W  = 8,
    parameter int RW = 44
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [W-1:0]  opnd [NOPND],
    input  logic                 wr_en,
    input  slot_e                wr_slot,
    input  logic signed [RW-1:0] wr_data,
    input  slot_e                rd_x,
    input  slot_e                rd_y,
    output logic signed [RW-1:0] x,
    output logic signed [RW-1:0] y
);

    logic signed [RW-1:0] rf_d [NSLOT];
    logic signed [RW-1:0] rf_q [NSLOT];

    always_comb begin
        rf_d = rf_q;
        if (load) begin
            for (int i = 0; i < NOPND; i++)
                rf_d[i] = {{(RW-W){opnd[i][W-1]}}, opnd[i]};
        end else if (wr_en) begin
            rf_d[wr_slot] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign x = rf_q[rd_x];
    assign y = rf_q[rd_y];

endmodule

// File: rtl/quartic_alu.sv
module quartic_alu
    import quartic_pkg::*;
#(
    parameter int RW = 44
) (
    input  op_kind_e             kind,
    input  logic signed [RW-1:0] x,
    input  logic [1:0]           sh_x,
    input  logic signed [RW-1:0] y,
    input  logic [1:0]           sh_y,
    output logic signed [RW-1:0] res
);

    logic signed [RW-1:0] prod;
    logic signed [RW-1:0] sum;

    always_comb begin
        prod = x * y;
        sum  = (x <<< sh_x) + (y <<< sh_y);
        res  = (kind == OP_MUL) ? prod : sum;
    end

endmodule

// File: rtl/quartic_spline_eval.sv
module quartic_spline_eval
    import quartic_pkg::*;
#(
    parameter int W = 8,
    localparam int RW = 5 * W + 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [W-1:0]  u,
    input  logic signed [W-1:0]  v,
    input  logic signed [W-1:0]  z,
    input  logic signed [W-1:0]  a,
    input  logic signed [W-1:0]  b,
    input  logic signed [W-1:0]  w,
    input  logic signed [W-1:0]  q,
    output logic                 busy,
    output logic                 done,
    output logic signed [RW-1:0] result
);

    typedef struct packed {
        logic          done;
        logic [RW-1:0] result;
    } out_t;

    out_t out_d, out_q;

    logic                 load;
    uop_t                 cur_uop;
    logic signed [RW-1:0] opx, opy, alu_res;
    logic signed [W-1:0]  opnd [NOPND];

    always_comb begin
        opnd[S_U] = u;
        opnd[S_V] = v;
        opnd[S_Z] = z;
        opnd[S_A] = a;
        opnd[S_B] = b;
        opnd[S_W] = w;
        opnd[S_Q] = q;
    end

    quartic_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .load  (load),
        .uop   (cur_uop)
    );

    quartic_regfile #(.W(W), .RW(RW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .opnd    (opnd),
        .wr_en   (busy),
        .wr_slot (cur_uop.dst),
        .wr_data (alu_res),
        .rd_x    (cur_uop.src_x),
        .rd_y    (cur_uop.src_y),
        .x       (opx),
        .y       (opy)
    );

    quartic_alu #(.RW(RW)) u_alu (
        .kind (cur_uop.kind),
        .x    (opx),
        .sh_x (cur_uop.sh_x),
        .y    (opy),
        .sh_y (cur_uop.sh_y),
        .res  (alu_res)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = busy && cur_uop.last;
        if (busy && cur_uop.last) out_d.result = alu_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign done   = out_q.done;
    assign result = out_q.result;

endmodule

// File: rtl/quartic_chk.sv
module quartic_chk
    import quartic_pkg::*;
#(
    parameter int RW = 44
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [RW-1:0] result,
    input logic          mul_fire
);

    logic [STEP_W:0] lat_q;
    logic [STEP_W:0] mul_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            mul_q <= '0;
        end else if (start && !busy) begin
            lat_q <= '0;
            mul_q <= '0;
        end else if (busy) begin
            lat_q <= lat_q + 1'b1;
            mul_q <= mul_q + (mul_fire ? 1'b1 : 1'b0);
        end
    end

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == (STEP_W+1)'(NSTEP)) && !busy);

    // R3
    mul_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mul_q == (STEP_W+1)'(NMUL));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (lat_q != (STEP_W+1)'(NSTEP - 1)) |=> busy && !done);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind quartic_spline_eval quartic_chk #(.RW(RW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .mul_fire (busy && cur_uop.kind == quartic_pkg::OP_MUL)
);

// File: tb/quartic_spline_eval_test.sv
`timescale 1ns/1ps
module quartic_spline_eval_test;

    localparam int W    = 8;
    localparam int RW   = 5 * W + 4;
    localparam int LAT  = 16;
    localparam int RUNC = 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [W-1:0] u = '0, v = '0, z = '0, a = '0, b = '0, w = '0, q = '0;
    logic busy, done;
    logic signed [RW-1:0] result;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    quartic_spline_eval #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .u(u), .v(v), .z(z), .a(a), .b(b), .w(w), .q(q),
        .busy(busy), .done(done), .result(result)
    );

    function automatic longint poly(longint pu, longint pv, longint pz,
                                    longint pa, longint pb, longint pw,
                                    longint pq);
        return pz*pu*pu*pu*pu + 4*pa*pv*pu*pu*pu + 6*pb*pu*pu*pv*pv
             + 4*pw*pu*pv*pv*pv + pq*pv*pv*pv*pv;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference state
    logic   m_busy = 1'b0, m_done = 1'b0;
    int     m_cnt = 0;
    longint m_res = 0, m_pend = 0;

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R6: reset state
        check("R6", "busy in reset", longint'(busy), 0);
        check("R6", "done in reset", longint'(done), 0);
        check("R6", "result in reset", longint'(result), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < RUNC; cyc++) begin
            @(negedge clk);
            check(m_busy ? "R4" : "R2", "busy", longint'(busy), longint'(m_busy));
            check("R3", "done", longint'(done), longint'(m_done));
            check(m_done ? "R1" : "R5", "result", longint'(result), m_res);
            if (cyc == 0)
                check("R6", "result after reset", longint'(result), 0);

            // new stimulus for the next edge
            start = ($urandom % 3) == 0;
            case ($urandom % 8)
                0: begin u = -128; v = -128; z = -128; a = -128; b = -128; w = -128; q = -128; end
                1: begin u = 127;  v = 127;  z = 127;  a = 127;  b = 127;  w = 127;  q = 127;  end
                2: begin u = -128; v = 127;  z = 127;  a = -128; b = 127;  w = -128; q = 127;  end
                default: begin
                    u = W'($urandom); v = W'($urandom); z = W'($urandom);
                    a = W'($urandom); b = W'($urandom); w = W'($urandom);
                    q = W'($urandom);
                end
            endcase

            // reference: effect of the coming edge
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == LAT) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_res  = m_pend;
                end
            end else if (start) begin
                m_busy = 1'b1;
                m_cnt  = 0;
                m_pend = poly(longint'(u), longint'(v), longint'(z), longint'(a),
                              longint'(b), longint'(w), longint'(q));
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule